// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Capture

This block drives and samples up to six banks of 32 general-purpose pins from a simple synchronous register bus. Each pin has a direction bit that enables its output driver. Its output latch changes only through two strobe registers: one sets latch bits and the other clears them. The block reads the level of each pin after a two-flop synchronizer.

Every pin can record a rising and a falling transition in a sticky status bit. Two enable registers per bank decide which transitions count. Software clears a status bit by writing one to it. A per-bank mask register selects which status bits may drive the single combined interrupt line. The number of pins is a parameter, and the last bank may be only partly populated.

Banks 0 to 2 sit in a low address window and banks 3 to 5 in a second window 0x100 higher. Inside a window, the bank number selects one of three consecutive words within each register group. Reads are combinational from the address. Writes take effect at the clock edge where the write enable is sampled high.

Top module: `pinbank_ctrl`

## Requirements
- R1: Byte addresses decode as window base (0x000 for banks 0–2, 0x100 for banks 3–5) plus 4 × (bank mod 3) plus a group offset. The group offsets are: level 0x00, direction 0x0C, set 0x18, clear 0x24, rising enable 0x30, falling enable 0x3C, status 0x48, mask 0x9C. Bit n of a bank register belongs to pin 32 × bank + n.
- R2: Each direction bit drives `pin_oe` of its pin (1 = output, 0 = input). The direction register reads back as written.
- R3: Writing the set group forces the output latch to 1 wherever the written bit is 1. Bits written as 0 leave the latch unchanged. The set and clear groups read as 0.
- R4: Writing the clear group forces the output latch to 0 wherever the written bit is 1. Bits written as 0 leave the latch unchanged. The latch drives `pin_out`.
- R5: The level group returns each pin input after two register stages, so a change becomes visible after the second rising clock edge. Writes to the level group have no effect.
- R6: A status bit becomes 1 when its synchronized pin goes from 0 to 1 while the pin's rising-enable bit is 1. With the enable at 0, a rising transition leaves the bit at 0.
- R7: A status bit becomes 1 when its synchronized pin goes from 1 to 0 while the pin's falling-enable bit is 1. With the enable at 0, a falling transition leaves the bit at 0.
- R8: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R9: If a qualifying edge and a clearing write hit the same status bit in the same cycle, the bit stays 1. Other bits cleared by that write still clear.
- R10: `irq` is 1 exactly when some bank has a status bit that is 1 together with its mask bit.
- R11: After reset, direction, output latch, both edge enables, status and mask are all 0, so `pin_oe`, `pin_out` and `irq` are 0.
- R12: Bits of unpopulated pins read as 0 and cannot be set. An address that is misaligned, outside the groups, or in an absent bank reads as 0, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 12 | Byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | NUM_PINS | Pin inputs, asynchronous |
| pin_out | output | NUM_PINS | Output latch |
| pin_oe | output | NUM_PINS | Output enable per pin |
| irq | output | 1 | Combined masked edge interrupt |

## Verification
The bench times a clearing write to land in the same cycle as a fresh rising edge on the same bit. A design that let the clear win would lose that edge and read the bit as 0. It also checks the level readback exactly one and two edges after a pin change, which catches a missing or extra synchronizer stage. It writes through the upper window and into an absent bank, where a decoder that ignores the window bit or the bank count would alias onto banks 0 and 1. The partly filled last bank is written with all ones; a design without pin-count masking would read bits beyond the last pin as 1.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;

    localparam int BANK_BITS = 32;
    localparam int MAX_BANKS = 6;

    typedef enum logic [2:0] {
        RK_LEVEL = 3'd0,
        RK_DIR   = 3'd1,
        RK_SET   = 3'd2,
        RK_CLR   = 3'd3,
        RK_RISE  = 3'd4,
        RK_FALL  = 3'd5,
        RK_STS   = 3'd6,
        RK_MASK  = 3'd7
    } reg_kind_e;

    typedef struct packed {
        logic      valid;
        logic [2:0] bank;
        reg_kind_e kind;
    } dec_t;

endpackage

// File: rtl/pinbank_decode.sv
module pinbank_decode
    import pinbank_pkg::*;
#(
    parameter int NUM_BANKS = 3
) (
    input  logic [11:0] addr_i,
    output dec_t        dec_o
);
    localparam logic [3:0] NB        = 4'(NUM_BANKS);
    localparam logic [5:0] GRP_WORDS = 6'd21;
    localparam logic [5:0] MSK_FIRST = 6'd39;
    localparam logic [5:0] MSK_LAST  = 6'd41;

    logic [5:0] word;
    logic [1:0] sub;
    logic       hit;
    logic [2:0] bnk;

    always_comb begin
        word  = addr_i[7:2];
        sub   = 2'd0;
        hit   = 1'b0;
        dec_o = '{valid: 1'b0, bank: 3'd0, kind: RK_LEVEL};
        if (addr_i[11:9] == 3'd0 && addr_i[1:0] == 2'd0) begin
            if (word < GRP_WORDS) begin
                hit        = 1'b1;
                dec_o.kind = reg_kind_e'(3'(word / 6'd3));
                sub        = 2'(word % 6'd3);
            end else if (word >= MSK_FIRST && word <= MSK_LAST) begin
                hit        = 1'b1;
                dec_o.kind = RK_MASK;
                sub        = 2'(word - MSK_FIRST);
            end
        end
        bnk         = addr_i[8] ? (3'd3 + {1'b0, sub}) : {1'b0, sub};
        dec_o.bank  = bnk;
        dec_o.valid = hit && ({1'b0, bnk} < NB);
    end

endmodule

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
    parameter int N = 85
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pins_i,
    output logic [N-1:0] lvl_o,
    output logic [N-1:0] prev_o
);
    typedef struct packed {
        logic [N-1:0] s1;
        logic [N-1:0] s2;
        logic [N-1:0] prev;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d.s1   = pins_i;
        sync_d.s2   = sync_q.s1;
        sync_d.prev = sync_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign lvl_o  = sync_q.s2;
    assign prev_o = sync_q.prev;

    // R5: the edge reference is the level one cycle earlier
    a_r5_prev_follows: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (prev_o == $past(lvl_o)));

endmodule

// File: rtl/pinbank_bank.sv
module pinbank_bank
    import pinbank_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  reg_kind_e    kind_i,
    input  logic [W-1:0] wdata_i,
    input  logic [W-1:0] lvl_i,
    input  logic [W-1:0] prev_i,
    output logic [31:0]  rdata_o,
    output logic [W-1:0] dir_o,
    output logic [W-1:0] out_o,
    output logic         irq_o
);
    typedef struct packed {
        logic [W-1:0] dir;
        logic [W-1:0] out;
        logic [W-1:0] ren;
        logic [W-1:0] fen;
        logic [W-1:0] sts;
        logic [W-1:0] msk;
    } bank_t;

    bank_t        bank_d, bank_q;
    logic [W-1:0] rise, fall, evt;

    always_comb begin
        rise   = lvl_i & ~prev_i;
        fall   = ~lvl_i & prev_i;
        evt    = (rise & bank_q.ren) | (fall & bank_q.fen);
        bank_d = bank_q;
        if (wr_i) begin
            unique case (kind_i)
                RK_DIR:  bank_d.dir = wdata_i;
                RK_SET:  bank_d.out = bank_q.out | wdata_i;
                RK_CLR:  bank_d.out = bank_q.out & ~wdata_i;
                RK_RISE: bank_d.ren = wdata_i;
                RK_FALL: bank_d.fen = wdata_i;
                RK_STS:  bank_d.sts = bank_q.sts & ~wdata_i;
                RK_MASK: bank_d.msk = wdata_i;
                default: ;
            endcase
        end
        // a new edge overrides a same-cycle clear
        bank_d.sts = bank_d.sts | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    always_comb begin
        unique case (kind_i)
            RK_LEVEL: rdata_o = 32'(lvl_i);
            RK_DIR:   rdata_o = 32'(bank_q.dir);
            RK_RISE:  rdata_o = 32'(bank_q.ren);
            RK_FALL:  rdata_o = 32'(bank_q.fen);
            RK_STS:   rdata_o = 32'(bank_q.sts);
            RK_MASK:  rdata_o = 32'(bank_q.msk);
            default:  rdata_o = 32'd0;
        endcase
    end

    assign dir_o = bank_q.dir;
    assign out_o = bank_q.out;
    assign irq_o = |(bank_q.sts & bank_q.msk);

    a_r3_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && kind_i == RK_SET) |=> ((bank_q.out & $past(wdata_i)) == $past(wdata_i)));

    a_r4_clr_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && kind_i == RK_CLR) |=> ((bank_q.out & $past(wdata_i)) == '0));

    a_r9_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && kind_i == RK_STS && (evt & wdata_i) != '0)
        |=> ((bank_q.sts & $past(evt & wdata_i)) == $past(evt & wdata_i)));

    // R6 and R7: a status bit never rises without an enabled edge
    a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((bank_q.sts & ~$past(bank_q.sts) & ~$past(evt)) == '0));

    a_r10_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_q.msk == '0) |-> !irq_o);

endmodule

// File: rtl/pinbank_ctrl.sv
module pinbank_ctrl
    import pinbank_pkg::*;
#(
    parameter int NUM_PINS = 85
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [11:0]         bus_addr,
    input  logic                bus_we,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic                irq
);
    localparam int NUM_BANKS = (NUM_PINS + BANK_BITS - 1) / BANK_BITS;

    dec_t                dec;
    logic [NUM_PINS-1:0] lvl, prev;
    logic [31:0]         bank_rd  [NUM_BANKS];
    logic [NUM_BANKS-1:0] bank_irq;

    pinbank_decode #(.NUM_BANKS(NUM_BANKS)) u_dec (
        .addr_i (bus_addr),
        .dec_o  (dec)
    );

    pinbank_sync #(.N(NUM_PINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pins_i (pin_in),
        .lvl_o  (lvl),
        .prev_o (prev)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam int LO = b * BANK_BITS;
        localparam int W  = (NUM_PINS - LO > BANK_BITS) ? BANK_BITS : NUM_PINS - LO;
        logic sel;
        assign sel = bus_we && dec.valid && (dec.bank == 3'(b));
        pinbank_bank #(.W(W)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_i    (sel),
            .kind_i  (dec.kind),
            .wdata_i (bus_wdata[W-1:0]),
            .lvl_i   (lvl[LO +: W]),
            .prev_i  (prev[LO +: W]),
            .rdata_o (bank_rd[b]),
            .dir_o   (pin_oe[LO +: W]),
            .out_o   (pin_out[LO +: W]),
            .irq_o   (bank_irq[b])
        );
    end

    always_comb begin
        bus_rdata = 32'd0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (dec.valid && dec.bank == 3'(b)) bus_rdata = bank_rd[b];
        end
    end

    assign irq = |bank_irq;

    a_r12_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !dec.valid |-> (bus_rdata == 32'd0));

    a_r5_level_readonly: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && dec.kind == RK_LEVEL) |=> ($stable(pin_out) && $stable(pin_oe)));

endmodule

// File: tb/test_pinbank_ctrl.sv
module test_pinbank_ctrl;
    localparam int NP = 121;

    localparam logic [11:0] G_LVL = 12'h000, G_DIR = 12'h00C, G_SET = 12'h018,
                            G_CLR = 12'h024, G_RISE = 12'h030, G_FALL = 12'h03C,
                            G_STS = 12'h048, G_MSK = 12'h09C;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [11:0]   bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out, pin_oe;
    logic          irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    pinbank_ctrl #(.NUM_PINS(NP)) i_pinbank_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    function automatic logic [11:0] ra(input int bank, input logic [11:0] grp);
        logic [11:0] base;
        base = (bank < 3) ? 12'(bank * 4) : 12'(12'h100 + (bank - 3) * 4);
        return base + grp;
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(ra(0, G_DIR), d);  chk("R11 dir", d, 0);
        rd(ra(1, G_RISE), d); chk("R11 rise en", d, 0);
        rd(ra(2, G_STS), d);  chk("R11 status", d, 0);
        rd(ra(3, G_MSK), d);  chk("R11 mask", d, 0);
        chk("R11 pin_oe", 32'(|pin_oe), 0);
        chk("R11 pin_out", 32'(|pin_out), 0);
        chk("R11 irq", 32'(irq), 0);
    endtask

    task automatic t_dir();
        logic [31:0] d;
        wr(ra(0, G_DIR), 32'h0000_F00F);
        rd(ra(0, G_DIR), d);  chk("R2 dir readback", d, 32'h0000_F00F);
        chk("R2 pin_oe bank0", pin_oe[31:0], 32'h0000_F00F);
        wr(ra(1, G_DIR), 32'h8000_0001);
        chk("R1 R2 pin_oe bank1", pin_oe[63:32], 32'h8000_0001);
        chk("R2 bank0 untouched", pin_oe[31:0], 32'h0000_F00F);
    endtask

    task automatic t_setclr();
        logic [31:0] d;
        wr(ra(1, G_SET), 32'hA5A5_0000);
        chk("R3 set", pin_out[63:32], 32'hA5A5_0000);
        wr(ra(1, G_SET), 32'h0000_0003);
        chk("R3 set accumulates", pin_out[63:32], 32'hA5A5_0003);
        rd(ra(1, G_SET), d); chk("R3 set reads zero", d, 0);
        wr(ra(1, G_CLR), 32'h8000_0001);
        chk("R4 clear", pin_out[63:32], 32'h25A5_0002);
        wr(ra(1, G_CLR), 32'h0);
        chk("R4 clear zero no effect", pin_out[63:32], 32'h25A5_0002);
        rd(ra(1, G_CLR), d); chk("R3 clear reads zero", d, 0);
    endtask

    task automatic t_level();
        logic [31:0] d;
        @(negedge clk);
        pin_in[71:64] = 8'h5A;
        bus_addr = ra(2, G_LVL);
        @(negedge clk); #1 d = bus_rdata;
        chk("R5 level after one edge", d, 32'h0);
        @(negedge clk); #1 d = bus_rdata;
        chk("R5 level after two edges", d, 32'h5A);
        wr(ra(2, G_LVL), 32'hFFFF_FFFF);
        rd(ra(2, G_LVL), d); chk("R5 level write ignored", d, 32'h5A);
        chk("R5 level write no output", pin_out[95:64], 0);
    endtask

    task automatic t_edges();
        logic [31:0] d;
        wr(ra(0, G_RISE), 32'h0000_0008);
        wr(ra(0, G_FALL), 32'h0000_0010);
        @(negedge clk); pin_in[5:3] = 3'b111;
        settle();
        rd(ra(0, G_STS), d); chk("R6 rise enabled bit3 only", d, 32'h08);
        @(negedge clk); pin_in[5:3] = 3'b000;
        settle();
        rd(ra(0, G_STS), d); chk("R7 fall enabled bit4", d, 32'h18);
    endtask

    task automatic t_w1c();
        logic [31:0] d;
        wr(ra(0, G_STS), 32'h0);
        rd(ra(0, G_STS), d); chk("R8 write zero keeps", d, 32'h18);
        wr(ra(0, G_STS), 32'h08);
        rd(ra(0, G_STS), d); chk("R8 write one clears", d, 32'h10);
    endtask

    task automatic t_irq();
        logic [31:0] d;
        chk("R10 irq masked", 32'(irq), 0);
        wr(ra(0, G_MSK), 32'h0000_0010);
        chk("R10 irq unmasked", 32'(irq), 1);
        wr(ra(0, G_STS), 32'h10);
        rd(ra(0, G_STS), d); chk("R8 status cleared", d, 0);
        chk("R10 irq drops", 32'(irq), 0);
        wr(ra(0, G_MSK), 32'h0);
    endtask

    task automatic t_race();
        logic [31:0] d;
        @(negedge clk); pin_in[3] = 1'b1; pin_in[4] = 1'b1;
        settle();
        @(negedge clk); pin_in[3] = 1'b0; pin_in[4] = 1'b0;
        settle();
        rd(ra(0, G_STS), d); chk("R6 R7 pre-race status", d, 32'h18);
        pin_in[3] = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        bus_addr = ra(0, G_STS); bus_wdata = 32'h18; bus_we = 1'b1;
        @(negedge clk); bus_we = 1'b0;
        #1 d = bus_rdata;
        chk("R9 edge wins over clear", d, 32'h08);
    endtask

    task automatic t_upper();
        logic [31:0] d;
        wr(ra(3, G_DIR), 32'hFFFF_FFFF);
        rd(ra(3, G_DIR), d); chk("R12 partial bank dir", d, 32'h01FF_FFFF);
        chk("R1 window bank3 pin_oe", 32'(pin_oe[120:96]), 32'h01FF_FFFF);
        wr(ra(3, G_RISE), 32'h10);
        @(negedge clk); pin_in[100] = 1'b1;
        settle();
        rd(ra(3, G_STS), d); chk("R1 bank3 status", d, 32'h10);
        rd(ra(0, G_STS), d); chk("R1 no alias onto bank0", d, 32'h08);
        wr(ra(3, G_MSK), 32'h10);
        chk("R10 irq from bank3", 32'(irq), 1);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        wr(ra(4, G_DIR), 32'hFFFF_FFFF);
        rd(ra(4, G_DIR), d); chk("R12 absent bank reads 0", d, 0);
        rd(ra(1, G_DIR), d); chk("R12 absent bank no alias", d, 32'h8000_0001);
        wr(12'h054, 32'hFFFF_FFFF);
        rd(12'h054, d); chk("R12 gap reads 0", d, 0);
        wr(12'h00E, 32'hFFFF_FFFF);
        rd(ra(0, G_DIR), d); chk("R12 misaligned write ignored", d, 32'h0000_F00F);
        rd(12'h200, d); chk("R12 high address reads 0", d, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_dir();
        t_setclr();
        t_level();
        t_edges();
        t_w1c();
        t_irq();
        t_race();
        t_upper();
        t_unmapped();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule